// File: doc/BRIEF.md
# Frequency Watchdog with Safe-Code Fallback

This block supervises the clock-frequency selection of a clock generator. While armed, it counts time in fixed units, each one a set number of tick-clock cycles. The limit in units comes from an 8-bit count register. In the target system one unit stands for 290 ms, so the power-up count of 8 gives roughly 2.3 s. Software services the watchdog with a one-cycle strobe. If no strobe arrives before the limit is reached, the block sets a sticky alarm flag. It then replaces the selected frequency code with a 5-bit safe code and drives an active-low system reset pulse that lasts a fixed number of tick cycles.

In normal operation the effective frequency code comes from the latched strap pins or from the frequency register, as a source-select bit chooses. During an alarm a second select bit picks where the safe code comes from: the latched straps, or the safe-code register field. That field powers up as 0b01111. The watchdog enable bit is a register bit that powers up cleared. The alarm flag is cleared only by a register write strobe or by the power-on reset. The PLL itself lies outside this block.

Top module: `wdt_safe_freq`

## Requirements
- R1: After power-on reset the outputs are alarm_o = 0 and sys_rst_no = 1. freq_o follows the normal selection.
- R2: The block is armed while wd_en_i = 1 and alarm_o = 0. Counting restarts on the clock edge that samples kick_i, reg_wr_i or a low wd_en_i. If no such edge follows, alarm_o becomes 1 after exactly max(wd_count_i,1) x UNIT_TICKS further rising edges.
- R3: A kick_i strobe at any point before the timeout restarts the full period from zero.
- R4: While wd_en_i = 0, alarm_o never rises, however long this lasts. Setting wd_en_i to 1 starts the period from zero.
- R5: sys_rst_no goes low in the same cycle that alarm_o rises. It stays low for exactly RST_CYCLES (16) cycles and is high at all other times.
- R6: Once set, alarm_o stays 1 through kick_i strobes and through changes of wd_en_i. While alarm_o is 1 no further timeout and no second reset pulse occur.
- R7: A reg_wr_i strobe clears alarm_o on the next cycle and restarts the period. If it coincides with the timeout edge, the write wins: no alarm and no reset pulse.
- R8: With alarm_o = 0, freq_o equals hw_fs_i when freq_src_i = 0 and freq_reg_i when freq_src_i = 1.
- R9: With alarm_o = 1, freq_o equals hw_fs_i when safe_src_i = 0 and safe_code_i when safe_src_i = 1.
- R10: A count value of 0 behaves as a limit of one unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick-rate clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| wd_count_i | input | 8 | Timeout limit in units |
| wd_en_i | input | 1 | Watchdog enable register bit |
| kick_i | input | 1 | Service strobe, one cycle |
| reg_wr_i | input | 1 | Register write strobe; clears the alarm |
| hw_fs_i | input | 5 | Latched strap frequency code |
| freq_reg_i | input | 5 | Frequency register code |
| freq_src_i | input | 1 | Normal code source: 0 straps, 1 register |
| safe_code_i | input | 5 | Safe frequency register field |
| safe_src_i | input | 1 | Safe code source: 0 straps, 1 register field |
| freq_o | output | 5 | Effective frequency code |
| alarm_o | output | 1 | Sticky watchdog alarm status |
| sys_rst_no | output | 1 | Active-low system reset pulse |

## Verification
The assertions assume that kick_i and reg_wr_i are one-cycle strobes that arrive synchronous to clk_i. They also assume that the count, select and code inputs change only between clock edges. The stimulus drives every input at the falling edge and holds each strobe for exactly one cycle. It draws random codes, limits and service points with $urandom under a fixed seed, and it places the directed corner cases on exact edges: a write on the timeout edge, a count of zero, and a long disabled interval.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    WD_OFF  = 2'd0,
    WD_RUN  = 2'd1,
    WD_TRIP = 2'd2
  } wd_state_e;

  function automatic logic [8:0] eff_limit(input logic [7:0] cnt);
    eff_limit = (cnt == 8'd0) ? 9'd1 : {1'b0, cnt};
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int UNIT_TICKS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic unit_o
);
  localparam int PW = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(UNIT_TICKS - 1);

  logic [PW-1:0] pre_q;

  assign unit_o = run_i && (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pre_q <= '0;
    else if (clr_i)       pre_q <= '0;
    else if (unit_o)      pre_q <= '0;
    else if (run_i)       pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdt_unit_cnt.sv
module wdt_unit_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             unit_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  import wdt_pkg::*;

  logic [CNT_W-1:0] units_q;
  logic [CNT_W:0]   next_units;

  assign next_units = {1'b0, units_q} + 1'b1;
  assign expire_o   = unit_i && (next_units >= eff_limit(limit_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        units_q <= '0;
    else if (clr_i)     units_q <= '0;
    else if (expire_o)  units_q <= '0;
    else if (unit_i)    units_q <= next_units[CNT_W-1:0];
  end
endmodule

// File: rtl/wdt_rst_gen.sv
module wdt_rst_gen #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic rst_no
);
  localparam int RW = $clog2(RST_CYCLES + 1);

  logic [RW-1:0] left_q;

  assign rst_no = (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            left_q <= '0;
    else if (fire_i)        left_q <= RW'(RST_CYCLES);
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/wdt_freq_sel.sv
module wdt_freq_sel #(
  parameter int FS_W = 5
) (
  input  logic            alarm_i,
  input  logic [FS_W-1:0] hw_fs_i,
  input  logic [FS_W-1:0] freq_reg_i,
  input  logic            freq_src_i,
  input  logic [FS_W-1:0] safe_code_i,
  input  logic            safe_src_i,
  output logic [FS_W-1:0] freq_o
);
  logic [FS_W-1:0] norm_code, safe_code;

  assign norm_code = freq_src_i ? freq_reg_i  : hw_fs_i;
  assign safe_code = safe_src_i ? safe_code_i : hw_fs_i;
  assign freq_o    = alarm_i ? safe_code : norm_code;
endmodule

// File: rtl/wdt_safe_freq.sv
module wdt_safe_freq #(
  parameter int UNIT_TICKS = 32,
  parameter int CNT_W      = 8,
  parameter int FS_W       = 5,
  parameter int RST_CYCLES = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CNT_W-1:0] wd_count_i,
  input  logic            wd_en_i,
  input  logic            kick_i,
  input  logic            reg_wr_i,
  input  logic [FS_W-1:0] hw_fs_i,
  input  logic [FS_W-1:0] freq_reg_i,
  input  logic            freq_src_i,
  input  logic [FS_W-1:0] safe_code_i,
  input  logic            safe_src_i,
  output logic [FS_W-1:0] freq_o,
  output logic            alarm_o,
  output logic            sys_rst_no
);
  import wdt_pkg::*;

  wd_state_e state;
  logic      alarm_q, clr, run, unit, expire, trip;

  assign clr   = kick_i || reg_wr_i || !wd_en_i;
  assign run   = wd_en_i && !alarm_q && !clr;
  assign trip  = expire && !reg_wr_i;

  always_comb begin
    if (alarm_q)      state = WD_TRIP;
    else if (wd_en_i) state = WD_RUN;
    else              state = WD_OFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       alarm_q <= 1'b0;
    else if (reg_wr_i)                 alarm_q <= 1'b0;
    else if (state == WD_RUN && trip)  alarm_q <= 1'b1;
  end

  wdt_prescaler #(.UNIT_TICKS(UNIT_TICKS)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .run_i(run), .unit_o(unit)
  );

  wdt_unit_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .unit_i(unit),
    .limit_i(wd_count_i), .expire_o(expire)
  );

  wdt_rst_gen #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(trip), .rst_no(sys_rst_no)
  );

  wdt_freq_sel #(.FS_W(FS_W)) u_sel (
    .alarm_i(alarm_q), .hw_fs_i(hw_fs_i), .freq_reg_i(freq_reg_i),
    .freq_src_i(freq_src_i), .safe_code_i(safe_code_i),
    .safe_src_i(safe_src_i), .freq_o(freq_o)
  );

  assign alarm_o = alarm_q;
endmodule

// File: rtl/wdt_safe_freq_chk.sv
module wdt_safe_freq_chk #(
  parameter int FS_W       = 5,
  parameter int RST_CYCLES = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wd_en_i,
  input logic            kick_i,
  input logic            reg_wr_i,
  input logic [FS_W-1:0] hw_fs_i,
  input logic [FS_W-1:0] freq_reg_i,
  input logic            freq_src_i,
  input logic [FS_W-1:0] safe_code_i,
  input logic            safe_src_i,
  input logic [FS_W-1:0] freq_o,
  input logic            alarm_o,
  input logic            sys_rst_no
);
  localparam int LW = $clog2(RST_CYCLES + 2) + 1;
  logic [LW-1:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          low_q <= '0;
    else if (!sys_rst_no) low_q <= low_q + 1'b1;
    else                  low_q <= '0;
  end

  p_rst_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_q <= LW'(RST_CYCLES));

  p_rst_starts_with_alarm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_no) |-> $rose(alarm_o));

  p_alarm_brings_rst_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> !sys_rst_no);

  p_alarm_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o && !reg_wr_i) |=> alarm_o);

  p_kick_no_trip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> !$rose(alarm_o));

  p_wr_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |=> !alarm_o);

  p_off_no_alarm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wd_en_i && !alarm_o) |=> !alarm_o);

  p_norm_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alarm_o |-> freq_o == (freq_src_i ? freq_reg_i : hw_fs_i));

  p_safe_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> freq_o == (safe_src_i ? safe_code_i : hw_fs_i));
endmodule

bind wdt_safe_freq wdt_safe_freq_chk #(.FS_W(FS_W), .RST_CYCLES(RST_CYCLES)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wd_en_i(wd_en_i), .kick_i(kick_i),
  .reg_wr_i(reg_wr_i), .hw_fs_i(hw_fs_i), .freq_reg_i(freq_reg_i),
  .freq_src_i(freq_src_i), .safe_code_i(safe_code_i), .safe_src_i(safe_src_i),
  .freq_o(freq_o), .alarm_o(alarm_o), .sys_rst_no(sys_rst_no)
);

// File: tb/wdt_safe_freq_tb_top.sv
module wdt_safe_freq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int UNIT = 32;
  localparam int RSTC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] wd_count = 8'd8;
  logic wd_en = 1'b0, kick = 1'b0, reg_wr = 1'b0;
  logic [4:0] hw_fs = 5'd0, freq_reg = 5'd0, safe_code = 5'b01111;
  logic freq_src = 1'b0, safe_src = 1'b0;
  logic [4:0] freq;
  logic alarm, sys_rst_n;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_safe_freq #(.UNIT_TICKS(UNIT), .RST_CYCLES(RSTC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wd_count_i(wd_count), .wd_en_i(wd_en),
    .kick_i(kick), .reg_wr_i(reg_wr), .hw_fs_i(hw_fs), .freq_reg_i(freq_reg),
    .freq_src_i(freq_src), .safe_code_i(safe_code), .safe_src_i(safe_src),
    .freq_o(freq), .alarm_o(alarm), .sys_rst_no(sys_rst_n)
  );

  function automatic int period(input logic [7:0] n);
    return ((n == 8'd0) ? 1 : int'(n)) * UNIT;
  endfunction

  function automatic logic [4:0] exp_code(input logic alm, input logic fsrc,
      input logic [4:0] freg, input logic ssrc, input logic [4:0] scode,
      input logic [4:0] hw);
    if (alm) return ssrc ? scode : hw;
    return fsrc ? freg : hw;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_kick();
    kick = 1'b1; @(negedge clk); kick = 1'b0;
  endtask

  task automatic pulse_wr();
    reg_wr = 1'b1; @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic check_timeout(input string req, input logic [7:0] n);
    wait_n(period(n) - 1);
    check({req, " before limit"}, alarm, 0);
    wait_n(1);
    check({req, " at limit"}, alarm, 1);
    check({req, " reset low"}, sys_rst_n, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1977));
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    check("R1 alarm", alarm, 0);
    check("R1 reset out", sys_rst_n, 1);
    check("R1 code", freq, hw_fs);

    // R8 normal selection, random codes
    for (int i = 0; i < 16; i++) begin
      hw_fs = 5'($urandom); freq_reg = 5'($urandom); freq_src = 1'($urandom);
      #1;
      check("R8 normal code", freq, exp_code(1'b0, freq_src, freq_reg, safe_src, safe_code, hw_fs));
      wait_n(1);
    end

    // R2 timeout
    wd_count = 8'd3; wd_en = 1'b1;
    pulse_kick();
    check_timeout("R2", wd_count);

    // R5 pulse length
    wait_n(RSTC - 1);
    check("R5 still low", sys_rst_n, 0);
    wait_n(1);
    check("R5 released", sys_rst_n, 1);

    // R9 safe selection
    for (int i = 0; i < 8; i++) begin
      hw_fs = 5'($urandom); safe_code = 5'($urandom); safe_src = 1'($urandom);
      freq_reg = 5'($urandom); freq_src = 1'($urandom);
      #1;
      check("R9 safe code", freq, exp_code(1'b1, freq_src, freq_reg, safe_src, safe_code, hw_fs));
      wait_n(1);
    end

    // R6 sticky alarm, no second pulse
    begin
      int lows = 0;
      for (int i = 0; i < 3 * period(wd_count); i++) begin
        if (i % 40 == 0) kick = 1'b1;
        if (i == 50) wd_en = 1'b0;
        if (i == 90) wd_en = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        if (!sys_rst_n) lows++;
      end
      check("R6 alarm held", alarm, 1);
      check("R6 no second pulse", lows, 0);
    end

    // R7 write clears, then restart
    pulse_wr();
    check("R7 cleared", alarm, 0);
    check_timeout("R7 restart", wd_count);
    pulse_wr();
    // R7 write on the timeout edge
    wait_n(period(wd_count) - 1);
    pulse_wr();
    check("R7 collide alarm", alarm, 0);
    check("R7 collide reset", sys_rst_n, 1);

    // R3 service at random points
    for (int i = 0; i < 4; i++) begin
      int w;
      wd_count = 8'(1 + ($urandom % 4));
      pulse_wr();
      w = int'($urandom % (period(wd_count) - 1));
      wait_n(w);
      check("R3 pre-kick", alarm, 0);
      pulse_kick();
      check_timeout("R3 after kick", wd_count);
      wait_n(RSTC);
    end

    // R10 zero count
    wd_count = 8'd0;
    pulse_wr();
    check_timeout("R10", wd_count);
    wait_n(RSTC);

    // R4 disabled then enabled
    wd_count = 8'd2;
    wd_en = 1'b0;
    pulse_wr();
    wait_n(4 * period(wd_count));
    check("R4 disabled", alarm, 0);
    check("R4 no reset", sys_rst_n, 1);
    wd_en = 1'b1;
    check_timeout("R4 enable", wd_count);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule